// File: doc/BRIEF.md
# Ramp-Compare Conversion Counter

This block is the digital half of a single-slope converter. A fast clock advances a counter while an external ramp rises toward the held sample; an analog comparator, seen here as a plain digital input, goes high once the ramp has crossed the sample. The count reached at that moment is the conversion result.

The counter is one bit wider than the result. If the comparator never fires, or is stuck high from the start, the count cannot wrap back to small codes. Once the extra bit sets, the count freezes and the block raises an overflow flag with a saturated code. The comparator passes through a synchronizer before it can stop the count. A synchronous, active-high reset clears the count and holds it at zero. While reset is high the synchronizer keeps sampling, so a comparator that is already high when reset is released stops the count at zero on the first edge.

A done flag tells the consumer that the code is final. It stays set until the next reset. The intended clock is about 2.5 GHz, so the full 4096-count range fits inside a 2 µs conversion window.

Top module: `wadc_conv_top`

## Requirements
- R1: While `rst_i` is high at a clock edge, that edge leaves `code_o` at 0, `ovf_o` at 0 and `done_o` at 0, whatever `cmp_i` does.
- R2: After reset is released with the comparator low, `code_o` equals the number of clock edges seen with `rst_i` low, rising by one each edge.
- R3: `cmp_i` reaches the stop logic through a synchronizer of SYNC_STAGES flops (default 2). If `cmp_i` rises between the edges that make the count k and k+1, the frozen code is k + SYNC_STAGES.
- R4: `done_o` rises on the edge at which the count first holds its value. After that, `code_o`, `ovf_o` and `done_o` stay unchanged until reset, even if `cmp_i` falls or toggles.
- R5: When the internal 13-bit count reaches 4096 (2^CODE_W), the count freezes, `ovf_o` and `done_o` go to 1, and `code_o` reads all ones (4095).
- R6: If `cmp_i` is high for at least SYNC_STAGES edges before reset is released, the first edge after release sets `done_o` with `code_o` at 0 and `ovf_o` at 0.
- R7: A comparator rise that leads to a freeze at 4095 or below gives that code with `ovf_o` at 0. For example, a rise at count 4093 gives 4095. A rise at count 4094 or later is too late, and the conversion ends in overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast counter clock |
| rst_i | input | 1 | Synchronous active-high reset; holds the count at zero |
| cmp_i | input | 1 | Comparator output; high once the ramp crosses the sample |
| code_o | output | CODE_W (12) | Conversion code, saturated to all ones on overflow |
| ovf_o | output | 1 | Count ran past the code range |
| done_o | output | 1 | Result is final; sticky until reset |

## Verification
The bench first aims at the synchronizer latency. It raises the comparator at several known counts and expects exactly SYNC_STAGES extra counts. A design that gated the count with the raw input, or that added a stage, would be off by one or more. It then runs the top of the range. Comparator rises at 4093 and 4094 fall on either side of the overflow boundary, and a silent comparator must yield a saturated 4095 with the overflow flag, not a wrapped 0. Finally, the comparator is left high through reset, which must give code 0 on the first edge. It is also dropped and raised again after a stop, which must leave the result untouched; a design without a sticky freeze would resume counting.

// File: rtl/wadc_pkg.sv
package wadc_pkg;

    parameter int CODE_W      = 12;
    parameter int SYNC_STAGES = 2;

    localparam int CNT_W = CODE_W + 1;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        code_t code;
        logic  ovf;
        logic  done;
    } result_t;

    function automatic code_t sat_code(input cnt_t c);
        return c[CNT_W-1] ? {CODE_W{1'b1}} : c[CODE_W-1:0];
    endfunction

    function automatic logic at_last(input cnt_t c);
        return (c[CNT_W-1] == 1'b0) && (&c[CODE_W-1:0]);
    endfunction

endpackage

// File: rtl/wadc_sync.sv
module wadc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic d_i,
    output logic q_o
);
    generate
        if (STAGES <= 1) begin : g_single
            logic s_q;
            always_ff @(posedge clk_i) s_q <= d_i;
            assign q_o = s_q;
        end else begin : g_chain
            logic [STAGES-1:0] s_q;
            always_ff @(posedge clk_i) s_q <= {s_q[STAGES-2:0], d_i};
            assign q_o = s_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/wadc_counter.sv
module wadc_counter
    import wadc_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_i,
    output cnt_t cnt_o
);
    cnt_t cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)      cnt_q <= '0;
        else if (run_i) cnt_q <= cnt_q + cnt_t'(1);
    end

    assign cnt_o = cnt_q;

    // R5
    msb_clean_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q[CNT_W-1] |-> (cnt_q[CODE_W-1:0] == '0));

    // R1
    rst_clear_chk: assert property (@(posedge clk_i)
        rst_i |=> (cnt_q == '0));
endmodule

// File: rtl/wadc_ctrl.sv
module wadc_ctrl
    import wadc_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic cmp_s_i,
    input  cnt_t cnt_i,
    output logic run_o,
    output logic done_o
);
    logic done_q;
    logic hit_top;

    assign hit_top = at_last(cnt_i);
    assign run_o   = !rst_i && !done_q && !cmp_s_i && !cnt_i[CNT_W-1];

    always_ff @(posedge clk_i) begin
        if (rst_i)                       done_q <= 1'b0;
        else if (cmp_s_i)                done_q <= 1'b1;
        else if (run_o && hit_top)       done_q <= 1'b1;
    end

    assign done_o = done_q;

    // R4
    done_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        done_q |=> done_q);

    // R5
    top_stops_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_i[CNT_W-1] |-> !run_o);
endmodule

// File: rtl/wadc_conv_top.sv
module wadc_conv_top
    import wadc_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              cmp_i,
    output logic [CODE_W-1:0] code_o,
    output logic              ovf_o,
    output logic              done_o
);
    logic    cmp_s;
    logic    run;
    logic    done;
    cnt_t    cnt;
    result_t res;

    wadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .d_i   (cmp_i),
        .q_o   (cmp_s)
    );

    wadc_ctrl u_ctrl (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .cmp_s_i (cmp_s),
        .cnt_i   (cnt),
        .run_o   (run),
        .done_o  (done)
    );

    wadc_counter u_cnt (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .run_i (run),
        .cnt_o (cnt)
    );

    always_comb begin
        res.code = sat_code(cnt);
        res.ovf  = cnt[CNT_W-1];
        res.done = done;
    end

    assign code_o = res.code;
    assign ovf_o  = res.ovf;
    assign done_o = res.done;

    // R2
    count_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!done_o && !cmp_s && !ovf_o) |=> (cnt == $past(cnt) + cnt_t'(1)));

    // R4
    frozen_stable_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> ($stable(code_o) && $stable(ovf_o)));

    // R5
    ovf_done_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ovf_o |-> (done_o && (&code_o)));

    // R1
    rst_outputs_chk: assert property (@(posedge clk_i)
        rst_i |=> (!done_o && !ovf_o && (code_o == '0)));
endmodule

// File: tb/wadc_conv_top_bench.sv
module wadc_conv_top_bench;
    import wadc_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmp = 1'b0;
    logic [CODE_W-1:0] code;
    logic              ovf;
    logic              done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    localparam int MAXC = (1 << CODE_W) - 1;

    always #5 clk = ~clk;

    wadc_conv_top u_wadc_conv_top (
        .clk_i  (clk),
        .rst_i  (rst),
        .cmp_i  (cmp),
        .code_o (code),
        .ovf_o  (ovf),
        .done_o (done)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_res(input string req, input int ecode, input bit eovf, input bit edone);
        check(code == ecode, req, "code", int'(code), ecode);
        check(ovf == eovf, req, "ovf", int'(ovf), int'(eovf));
        check(done == edone, req, "done", int'(done), int'(edone));
    endtask

    task automatic start(input bit cmp_level);
        rst = 1'b1;
        cmp = cmp_level;
        step(4);
        rst = 1'b0;
    endtask

    // R1: reset holds everything at zero even while the comparator toggles
    task automatic t_reset_hold();
        start(1'b0);
        step(20);
        rst = 1'b1;
        for (int i = 0; i < 8; i++) begin
            cmp = i[0];
            step(1);
            check_res("R1", 0, 1'b0, 1'b0);
        end
        cmp = 1'b0;
    endtask

    // R2: free counting with the comparator low
    task automatic t_count(input int n);
        start(1'b0);
        step(n);
        check_res("R2", n, 1'b0, 1'b0);
        step(1);
        check_res("R2", n + 1, 1'b0, 1'b0);
    endtask

    // R3 and R4: comparator stop with synchronizer latency, then sticky freeze
    task automatic t_cmp_stop(input int k);
        start(1'b0);
        step(k);
        cmp = 1'b1;
        step(SYNC_STAGES);
        check(done == 1'b0, "R3", "done before sync", int'(done), 0);
        step(1);
        check_res("R3", k + SYNC_STAGES, 1'b0, 1'b1);
        cmp = 1'b0;
        step(10);
        check_res("R4", k + SYNC_STAGES, 1'b0, 1'b1);
        cmp = 1'b1;
        step(3);
        cmp = 1'b0;
        step(5);
        check_res("R4", k + SYNC_STAGES, 1'b0, 1'b1);
    endtask

    // R6: comparator already high at reset release
    task automatic t_high_at_release();
        start(1'b1);
        step(1);
        check_res("R6", 0, 1'b0, 1'b1);
        step(6);
        check_res("R6", 0, 1'b0, 1'b1);
        cmp = 1'b0;
    endtask

    // R5: silent comparator saturates, later comparator has no effect
    task automatic t_overflow();
        start(1'b0);
        step(MAXC);
        check_res("R5", MAXC, 1'b0, 1'b0);
        step(1);
        check_res("R5", MAXC, 1'b1, 1'b1);
        cmp = 1'b1;
        step(6);
        check_res("R5", MAXC, 1'b1, 1'b1);
        cmp = 1'b0;
    endtask

    // R7: comparator rising near the top of the range
    task automatic t_edge(input int k, input bit expect_ovf);
        start(1'b0);
        step(k);
        cmp = 1'b1;
        step(SYNC_STAGES + 4);
        check_res("R7", expect_ovf ? MAXC : k + SYNC_STAGES, expect_ovf, 1'b1);
        cmp = 1'b0;
    endtask

    initial begin
        step(1);
        check_res("R1", 0, 1'b0, 1'b0);
        t_reset_hold();
        t_count(1);
        t_count(37);
        t_cmp_stop(0);
        t_cmp_stop(5);
        t_cmp_stop(250);
        t_high_at_release();
        t_overflow();
        t_edge(MAXC - 2 - SYNC_STAGES + 2 - 0, 1'b0);
        t_edge(MAXC - 1, 1'b1);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule